// File: doc/BRIEF.md
# Cycle-Bit Descriptor Ring Pointer Engine

This block keeps the producer and consumer positions of a circular ring of 16-byte descriptors. The ring is split into equal segments. Each position is one descriptor slot. The producer advances its pointer when it has written a descriptor, and the consumer advances its pointer when it has used one. Ownership is not decided by a fill count. Each side holds a one-bit phase (cycle state), and the consumer owns a fetched descriptor only when the descriptor's cycle bit matches the consumer phase.

The engine has two modes. In chained mode, a small per-slot table marks which slots are link descriptors, gives each link's target slot, and says whether passing the link inverts the phase. A pointer never rests on a link slot. When the producer passes a link, the engine flips that link's stored cycle bit and copies in the chain flag of the descriptor just written. In event mode the link table is ignored. Pointers simply step through the segments in order, and the phase inverts only when a pointer wraps from the final slot of the final segment back to slot 0.

Besides the pointers, phases and empty/full flags, the block answers a room query for N further descriptors. It also checks ownership combinationally and pulses an error when an enqueue is refused.

Top module: `desc_ring_ptr_engine`

## Requirements
- R1: After reset both pointers are slot 0, both cycle states are 0, `empty` is 1, `full` is 0 and `ovf_err` is 0. Every link table entry is cleared: not a link, no toggle, target 0, stored cycle and chain bits 0.
- R2: `empty` is 1 exactly when the two pointers are equal. `full` is 1 exactly when one advance of the enqueue pointer (with link traversal) would equal the dequeue pointer. As a result, a ring with U usable slots holds at most U-1 entries.
- R3: In chained mode, an advance first steps to the next flat slot index (segment in the upper pointer bits, slot in the lower bits, wrapping modulo the ring size). While the slot reached is a link, the pointer loads that link's target. This repeats for up to HOPS consecutive links (default 2), so a pointer never rests on a link.
- R4: Passing a link whose toggle flag is set inverts the cycle state of the side that advanced: `prod_cycle` for enqueue, `cons_cycle` for dequeue. Passing a link without the flag leaves the cycle state unchanged. Without any advance, neither cycle state changes.
- R5: In event mode the link table is ignored. Pointers step by flat index, so after the last slot of a segment they move to slot 0 of the next segment. The cycle state inverts only on the wrap from the all-ones index back to 0. No stored link cycle bit changes in this mode.
- R6: In chained mode, every link passed by an accepted enqueue gets its stored cycle bit inverted and its stored chain bit set to `enq_chain`. A dequeue that passes the same link leaves both bits unchanged. A configuration write sets a slot's link, toggle and target fields and clears its stored cycle and chain bits. `rd_idx` reads the stored bits back combinationally.
- R7: An enqueue request while `full` is 1 is ignored: the pointer and the cycle state hold. `ovf_err` is then 1 for exactly the next cycle and is 0 at every other time.
- R8: A dequeue request while `empty` is 1 is ignored.
- R9: When enqueue and dequeue requests arrive in the same cycle, each one that is allowed takes effect. `empty` and `full` then reflect the updated pointers.
- R10: `room_ok` is 1 when none of the first `room_need` successive enqueue positions after the current one (with traversal) equals the dequeue pointer. This means room_need+1 slots are free. A `room_need` of 0 always gives 1.
- R11: `owned` is 1 exactly when `fetched_cycle` equals `cons_cycle`.
- R12: `enq_addr` and `deq_addr` are the byte offsets of the pointed slots, which is the pointer times 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_mode | input | 1 | 1: event ring (no links); 0: chained ring |
| enq_adv | input | 1 | Advance producer pointer |
| enq_chain | input | 1 | Chain flag of the descriptor being enqueued |
| deq_adv | input | 1 | Advance consumer pointer |
| cfg_we | input | 1 | Write one link table entry |
| cfg_idx | input | PW | Slot written |
| cfg_link | input | 1 | Slot is a link descriptor |
| cfg_toggle | input | 1 | Passing this link inverts the cycle state |
| cfg_target | input | PW | Link target slot |
| rd_idx | input | PW | Slot whose stored link bits are read |
| rd_cycle | output | 1 | Stored link cycle bit of `rd_idx` |
| rd_chain | output | 1 | Stored link chain bit of `rd_idx` |
| fetched_cycle | input | 1 | Cycle bit of a fetched descriptor |
| owned | output | 1 | Fetched descriptor belongs to the consumer |
| room_need | input | ROOM_W | Descriptor count for the room query |
| room_ok | output | 1 | Room for `room_need` plus the reserved slot |
| enq_ptr | output | PW | Producer slot index |
| deq_ptr | output | PW | Consumer slot index |
| enq_addr | output | PW+4 | Producer byte offset |
| deq_addr | output | PW+4 | Consumer byte offset |
| prod_cycle | output | 1 | Producer cycle state |
| cons_cycle | output | 1 | Consumer cycle state |
| empty | output | 1 | Pointers equal |
| full | output | 1 | One more enqueue would meet the consumer |
| ovf_err | output | 1 | One-cycle pulse after a refused enqueue |

## Verification
On every cycle the assertions check these rules: a refused enqueue holds the pointer and produces a single pulse, an empty dequeue is held, a cycle state never moves without an advance, no mid-ring event-mode step flips the phase, and the link table's stored bits stay put in event mode. Only the bench scenarios can show the actual traversal results. These include the target loaded from a link, two consecutive links crossed in one step, the phase inverted at the right wrap, and the chain flag copied into a passed link. They also include the capacity of one less than the usable slots and the room answers counted over link slots.

// File: rtl/ring_pkg.sv
package ring_pkg;
  parameter int SEG_W  = 2;
  parameter int SLOT_W = 2;
  parameter int HOPS   = 2;
  parameter int ROOM_W = 3;
  localparam int PW        = SEG_W + SLOT_W;
  localparam int TOTAL     = 1 << PW;
  localparam int DESC_SH   = 4;
  localparam int ROOM_MAX  = (1 << ROOM_W) - 1;

  typedef logic [PW-1:0] ptr_t;
  typedef logic [TOTAL-1:0] slot_vec_t;
  typedef logic [TOTAL-1:0][PW-1:0] tgt_vec_t;

  // Position after one advance, following up to HOPS links.
  function automatic ptr_t next_ptr(ptr_t cur, logic evt, slot_vec_t lnk, tgt_vec_t tgt);
    ptr_t q;
    q = cur + ptr_t'(1);
    if (!evt) begin
      for (int h = 0; h < HOPS; h++) begin
        if (lnk[q]) q = tgt[q];
      end
    end
    return q;
  endfunction

  // Whether the same advance inverts the cycle state.
  function automatic logic next_flip(ptr_t cur, logic evt, slot_vec_t lnk, slot_vec_t tgl,
                                     tgt_vec_t tgt);
    ptr_t q;
    logic f;
    q = cur + ptr_t'(1);
    f = 1'b0;
    if (evt) begin
      f = (cur == '1);
    end else begin
      for (int h = 0; h < HOPS; h++) begin
        if (lnk[q]) begin
          f = f ^ tgl[q];
          q = tgt[q];
        end
      end
    end
    return f;
  endfunction

  // Mask of link slots crossed by the advance.
  function automatic slot_vec_t links_passed(ptr_t cur, slot_vec_t lnk, tgt_vec_t tgt);
    ptr_t q;
    slot_vec_t m;
    q = cur + ptr_t'(1);
    m = '0;
    for (int h = 0; h < HOPS; h++) begin
      if (lnk[q]) begin
        m[q] = 1'b1;
        q = tgt[q];
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/ring_link_table.sv
module ring_link_table
  import ring_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      evt,
  input  logic      cfg_we,
  input  ptr_t      cfg_idx,
  input  logic      cfg_link,
  input  logic      cfg_toggle,
  input  ptr_t      cfg_target,
  input  logic      enq_fire,
  input  ptr_t      enq_ptr,
  input  logic      enq_chain,
  input  ptr_t      rd_idx,
  output slot_vec_t lnk,
  output slot_vec_t tgl,
  output tgt_vec_t  tgt,
  output logic      rd_cycle,
  output logic      rd_chain
);
  slot_vec_t lnk_q, tgl_q, cyc_q, chn_q;
  tgt_vec_t  tgt_q;
  slot_vec_t pass;

  always_comb begin
    pass = '0;
    if (enq_fire && !evt) pass = links_passed(enq_ptr, lnk_q, tgt_q);
  end

  for (genvar i = 0; i < TOTAL; i++) begin : g_entry
    logic wr_hit;
    logic upd_en;
    logic cyc_d, chn_d;
    logic lnk_d, tgl_d;
    ptr_t tgt_d;

    always_comb begin
      wr_hit = cfg_we && (cfg_idx == ptr_t'(i));
      upd_en = wr_hit || pass[i];
      lnk_d  = lnk_q[i];
      tgl_d  = tgl_q[i];
      tgt_d  = tgt_q[i];
      cyc_d  = cyc_q[i];
      chn_d  = chn_q[i];
      if (wr_hit) begin
        lnk_d = cfg_link;
        tgl_d = cfg_toggle;
        tgt_d = cfg_target;
        cyc_d = 1'b0;
        chn_d = 1'b0;
      end else if (pass[i]) begin
        cyc_d = ~cyc_q[i];
        chn_d = enq_chain;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lnk_q[i] <= 1'b0;
        tgl_q[i] <= 1'b0;
        tgt_q[i] <= '0;
        cyc_q[i] <= 1'b0;
        chn_q[i] <= 1'b0;
      end else if (upd_en) begin
        lnk_q[i] <= lnk_d;
        tgl_q[i] <= tgl_d;
        tgt_q[i] <= tgt_d;
        cyc_q[i] <= cyc_d;
        chn_q[i] <= chn_d;
      end
    end
  end

  assign lnk      = lnk_q;
  assign tgl      = tgl_q;
  assign tgt      = tgt_q;
  assign rd_cycle = cyc_q[rd_idx];
  assign rd_chain = chn_q[rd_idx];

  // R5: stored link bits never move in event mode except by configuration
  a_r5_evt_links_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !cfg_we) |=> ($stable(cyc_q) && $stable(chn_q)));
endmodule

// File: rtl/ring_ptr_reg.sv
module ring_ptr_reg
  import ring_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      evt,
  input  slot_vec_t lnk,
  input  slot_vec_t tgl,
  input  tgt_vec_t  tgt,
  output ptr_t      ptr_q,
  output logic      cyc_q
);
  ptr_t ptr_d;
  logic cyc_d;

  always_comb begin
    ptr_d = next_ptr(ptr_q, evt, lnk, tgt);
    cyc_d = cyc_q ^ next_flip(ptr_q, evt, lnk, tgl, tgt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cyc_q <= 1'b0;
    end else if (adv) begin
      ptr_q <= ptr_d;
      cyc_q <= cyc_d;
    end
  end

  // R4: the phase only moves on an advance
  a_r4_phase_needs_adv: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(cyc_q) && $stable(ptr_q)));
endmodule

// File: rtl/ring_room_check.sv
module ring_room_check
  import ring_pkg::*;
(
  input  logic              evt,
  input  ptr_t              enq_ptr,
  input  ptr_t              deq_ptr,
  input  slot_vec_t         lnk,
  input  tgt_vec_t          tgt,
  input  logic [ROOM_W-1:0] need,
  output logic              room_ok
);
  logic [ROOM_MAX:0][PW-1:0] walk;
  logic [ROOM_MAX:1]         hit;

  assign walk[0] = enq_ptr;

  for (genvar k = 1; k <= ROOM_MAX; k++) begin : g_walk
    assign walk[k] = next_ptr(walk[k-1], evt, lnk, tgt);
    assign hit[k]  = (walk[k] == deq_ptr) && (need >= ROOM_W'(k));
  end

  assign room_ok = ~|hit;
endmodule

// File: rtl/desc_ring_ptr_engine.sv
module desc_ring_ptr_engine
  import ring_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 event_mode,
  input  logic                 enq_adv,
  input  logic                 enq_chain,
  input  logic                 deq_adv,
  input  logic                 cfg_we,
  input  logic [PW-1:0]        cfg_idx,
  input  logic                 cfg_link,
  input  logic                 cfg_toggle,
  input  logic [PW-1:0]        cfg_target,
  input  logic [PW-1:0]        rd_idx,
  output logic                 rd_cycle,
  output logic                 rd_chain,
  input  logic                 fetched_cycle,
  output logic                 owned,
  input  logic [ROOM_W-1:0]    room_need,
  output logic                 room_ok,
  output logic [PW-1:0]        enq_ptr,
  output logic [PW-1:0]        deq_ptr,
  output logic [PW+DESC_SH-1:0] enq_addr,
  output logic [PW+DESC_SH-1:0] deq_addr,
  output logic                 prod_cycle,
  output logic                 cons_cycle,
  output logic                 empty,
  output logic                 full,
  output logic                 ovf_err
);
  slot_vec_t lnk, tgl;
  tgt_vec_t  tgt;
  ptr_t      enq_q, deq_q;
  logic      enq_fire, deq_fire;
  logic      ovf_d, ovf_q;

  always_comb begin
    empty    = (enq_q == deq_q);
    full     = (next_ptr(enq_q, event_mode, lnk, tgt) == deq_q);
    enq_fire = enq_adv && !full;
    deq_fire = deq_adv && !empty;
    ovf_d    = enq_adv && full;
  end

  ring_link_table u_links (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (event_mode),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_link   (cfg_link),
    .cfg_toggle (cfg_toggle),
    .cfg_target (cfg_target),
    .enq_fire   (enq_fire),
    .enq_ptr    (enq_q),
    .enq_chain  (enq_chain),
    .rd_idx     (rd_idx),
    .lnk        (lnk),
    .tgl        (tgl),
    .tgt        (tgt),
    .rd_cycle   (rd_cycle),
    .rd_chain   (rd_chain)
  );

  ring_ptr_reg u_prod (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (enq_fire),
    .evt   (event_mode),
    .lnk   (lnk),
    .tgl   (tgl),
    .tgt   (tgt),
    .ptr_q (enq_q),
    .cyc_q (prod_cycle)
  );

  ring_ptr_reg u_cons (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (deq_fire),
    .evt   (event_mode),
    .lnk   (lnk),
    .tgl   (tgl),
    .tgt   (tgt),
    .ptr_q (deq_q),
    .cyc_q (cons_cycle)
  );

  ring_room_check u_room (
    .evt     (event_mode),
    .enq_ptr (enq_q),
    .deq_ptr (deq_q),
    .lnk     (lnk),
    .tgt     (tgt),
    .need    (room_need),
    .room_ok (room_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign ovf_err  = ovf_q;
  assign owned    = (fetched_cycle == cons_cycle);
  assign enq_ptr  = enq_q;
  assign deq_ptr  = deq_q;
  assign enq_addr = {enq_q, {DESC_SH{1'b0}}};
  assign deq_addr = {deq_q, {DESC_SH{1'b0}}};

  // R7: a refused enqueue holds the producer side and pulses the error
  a_r7_refused_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_adv && full) |=> ($stable(enq_q) && $stable(prod_cycle) && ovf_err));
  // R7: no error pulse without a refused enqueue
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(enq_adv && full) |=> !ovf_err);
  // R8: dequeue on an empty ring is held
  a_r8_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_adv && empty) |=> ($stable(deq_q) && $stable(cons_cycle)));
  // R5: mid-ring event-mode steps keep the producer phase
  a_r5_evt_mid_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (event_mode && enq_adv && !full && enq_q != '1) |=> $stable(prod_cycle));
  // R2: the ring is never both empty and full
  a_r2_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
endmodule

// File: tb/desc_ring_ptr_engine_bench.sv
module desc_ring_ptr_engine_bench;
  import ring_pkg::*;

  localparam time CLK_P = 20ns;

  logic clk, rst_n, event_mode, enq_adv, enq_chain, deq_adv;
  logic cfg_we, cfg_link, cfg_toggle, fetched_cycle;
  logic [PW-1:0] cfg_idx, cfg_target, rd_idx;
  logic [ROOM_W-1:0] room_need;
  logic rd_cycle, rd_chain, owned, room_ok, prod_cycle, cons_cycle, empty, full, ovf_err;
  logic [PW-1:0] enq_ptr, deq_ptr;
  logic [PW+DESC_SH-1:0] enq_addr, deq_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic       e;
    logic       d;
    logic [3:0] xe;
    logic [3:0] xd;
    logic       xp;
    logic       xc;
    logic       xem;
    logic       xfu;
  } vec_t;

  // Event-mode walk from reset; a link configured at slot 3 must be ignored.
  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b0, 4'd1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 4'd2, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 4'd2, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 4'd2, 4'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b0, 4'd3, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 4'd4, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  desc_ring_ptr_engine u_desc_ring_ptr_engine (
    .clk(clk), .rst_n(rst_n), .event_mode(event_mode), .enq_adv(enq_adv),
    .enq_chain(enq_chain), .deq_adv(deq_adv), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_link(cfg_link), .cfg_toggle(cfg_toggle), .cfg_target(cfg_target),
    .rd_idx(rd_idx), .rd_cycle(rd_cycle), .rd_chain(rd_chain),
    .fetched_cycle(fetched_cycle), .owned(owned), .room_need(room_need),
    .room_ok(room_ok), .enq_ptr(enq_ptr), .deq_ptr(deq_ptr), .enq_addr(enq_addr),
    .deq_addr(deq_addr), .prod_cycle(prod_cycle), .cons_cycle(cons_cycle),
    .empty(empty), .full(full), .ovf_err(ovf_err)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; inputs are applied for one rising edge.
  task automatic step(input logic e, input logic d, input logic ch);
    enq_adv = e; deq_adv = d; enq_chain = ch;
    @(negedge clk);
    enq_adv = 1'b0; deq_adv = 1'b0; enq_chain = 1'b0;
  endtask

  task automatic cfg(input int idx, input logic lk, input logic tg, input int tg_slot);
    cfg_we = 1'b1; cfg_idx = PW'(idx); cfg_link = lk; cfg_toggle = tg;
    cfg_target = PW'(tg_slot);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset(input logic evt);
    rst_n = 1'b0; event_mode = evt;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic room_q(input string req, input int n, input logic exp);
    room_need = ROOM_W'(n);
    #1;
    chk(req, 32'(room_ok), 32'(exp));
  endtask

  task automatic rd_q(input string req, input int idx, input logic ec, input logic eh);
    rd_idx = PW'(idx);
    #1;
    chk({req, " cycle"}, 32'(rd_cycle), 32'(ec));
    chk({req, " chain"}, 32'(rd_chain), 32'(eh));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; event_mode = 1'b1; enq_adv = 1'b0; deq_adv = 1'b0; enq_chain = 1'b0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_link = 1'b0; cfg_toggle = 1'b0; cfg_target = '0;
    rd_idx = '0; fetched_cycle = 1'b0; room_need = '0;
    @(negedge clk);
    do_reset(1'b1);

    // R1: reset state
    chk("R1 enq", 32'(enq_ptr), 0);
    chk("R1 deq", 32'(deq_ptr), 0);
    chk("R1 pcs", 32'(prod_cycle), 0);
    chk("R1 ccs", 32'(cons_cycle), 0);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 ovf", 32'(ovf_err), 0);
    rd_q("R1 table", 3, 1'b0, 1'b0);

    // R5: event mode ignores a configured link
    cfg(3, 1'b1, 1'b1, 9);
    for (int i = 0; i < 6; i++) begin
      step(VEC[i].e, VEC[i].d, 1'b1);
      chk("R5/R8/R9 vec enq", 32'(enq_ptr), 32'(VEC[i].xe));
      chk("R5/R8/R9 vec deq", 32'(deq_ptr), 32'(VEC[i].xd));
      chk("R4 vec pcs", 32'(prod_cycle), 32'(VEC[i].xp));
      chk("R4 vec ccs", 32'(cons_cycle), 32'(VEC[i].xc));
      chk("R2 vec empty", 32'(empty), 32'(VEC[i].xem));
      chk("R2 vec full", 32'(full), 32'(VEC[i].xfu));
    end
    rd_q("R5 link bits untouched", 3, 1'b0, 1'b0);

    // R5/R2: fill to capacity 15, producer wraps 15->0 and toggles
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, 1'b0);
    chk("R5 wrap enq", 32'(enq_ptr), 2);
    chk("R5 wrap pcs", 32'(prod_cycle), 1);
    chk("R2 full at capacity", 32'(full), 1);
    room_q("R10 full need1", 1, 1'b0);
    room_q("R10 need0", 0, 1'b1);

    // R7: refused enqueue
    step(1'b1, 1'b0, 1'b0);
    chk("R7 enq held", 32'(enq_ptr), 2);
    chk("R7 pcs held", 32'(prod_cycle), 1);
    chk("R7 ovf pulse", 32'(ovf_err), 1);
    step(1'b0, 1'b0, 1'b0);
    chk("R7 ovf one cycle", 32'(ovf_err), 0);

    // R5: consumer wrap toggles
    for (int i = 0; i < 13; i++) step(1'b0, 1'b1, 1'b0);
    chk("R5 deq wrap", 32'(deq_ptr), 0);
    chk("R5 ccs wrap", 32'(cons_cycle), 1);
    chk("R2 not empty", 32'(empty), 0);
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b0);
    chk("R2 drained", 32'(empty), 1);
    fetched_cycle = 1'b0; #1;
    chk("R11 not owned", 32'(owned), 0);
    fetched_cycle = 1'b1; #1;
    chk("R11 owned", 32'(owned), 1);
    room_q("R10 empty need7", 7, 1'b1);
    chk("R12 enq addr", 32'(enq_addr), 32'h20);

    // Chained mode: seg0 slot3 -> 4, seg1 slot7 -> 0 with toggle
    do_reset(1'b0);
    cfg(3, 1'b1, 1'b0, 4);
    cfg(7, 1'b1, 1'b1, 0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1);
    chk("R3 skip link", 32'(enq_ptr), 4);
    chk("R4 no toggle flag", 32'(prod_cycle), 0);
    rd_q("R6 passed link", 3, 1'b1, 1'b1);
    rd_q("R6 unpassed link", 7, 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b0);
    chk("R2 chained enq", 32'(enq_ptr), 6);
    chk("R2 chained full", 32'(full), 1);
    room_q("R10 chained full need1", 1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk("R7 chained refuse", 32'(enq_ptr), 6);
    chk("R7 chained ovf", 32'(ovf_err), 1);
    step(1'b0, 1'b1, 1'b0);
    chk("R2 after deq", 32'(full), 0);
    step(1'b1, 1'b0, 1'b0);
    chk("R3 toggle link", 32'(enq_ptr), 0);
    chk("R4 pcs toggled", 32'(prod_cycle), 1);
    rd_q("R6 second link", 7, 1'b1, 1'b0);
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b0);
    chk("R3 consumer skip", 32'(deq_ptr), 4);
    rd_q("R6 consumer leaves link", 3, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0);
    chk("R4 ccs toggled", 32'(cons_cycle), 1);
    chk("R2 chained empty", 32'(empty), 1);
    room_q("R10 chained need5", 5, 1'b1);
    room_q("R10 chained need6", 6, 1'b0);

    // R9: simultaneous advance
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    chk("R9 enq", 32'(enq_ptr), 2);
    chk("R9 deq", 32'(deq_ptr), 1);
    chk("R9 flags", 32'({empty, full}), 0);
    chk("R12 deq addr", 32'(deq_addr), 32'h10);

    // R3: two consecutive links in one advance
    cfg(5, 1'b1, 1'b0, 7);
    rd_q("R6 cfg clears", 5, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk("R3 enq at 4", 32'(enq_ptr), 4);
    step(1'b1, 1'b0, 1'b0);
    chk("R3 two hops", 32'(enq_ptr), 0);
    chk("R4 two hops pcs", 32'(prod_cycle), 0);
    rd_q("R6 hop first", 5, 1'b1, 1'b0);
    rd_q("R6 hop second", 7, 1'b0, 1'b0);
    chk("R2 full after hops", 32'(full), 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule